// File: doc/BRIEF.md
# Configurable SPI Controller

This block is a full-duplex serial controller for a peripheral bus with one shared serial clock, one shared output data line, one shared input data line and a separate active-low select line for each peripheral. A command is presented on a set of configuration inputs: clock polarity, clock phase, bit order, target peripheral index, clock divider and one transmit byte. A single-cycle start request launches the exchange of that byte with the addressed peripheral.

While the exchange runs, the busy flag stays high. The block generates the serial clock from the system clock through a programmable divider. It drives the output data line and samples the input data line on the edges that the selected mode defines. At the end it releases the select line, pulses a done flag for one cycle and presents the received byte. All settings are captured when the transfer starts, so the command inputs are free to change while the transfer runs.

Top module: `spi_xfer_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, every select line is high, busy and done are low, the serial clock is low and the output data line is low.
- R2: A start request in an idle cycle sets busy on the next clock edge and pulls low only the select line whose bit index equals the target index. All other select lines stay high, and that one line stays low without interruption until the transfer ends.
- R3: The serial clock sits at the captured polarity level (0 = idles low, 1 = idles high) from the edge that asserts select, through the tail of the transfer, and for as long as the block is idle afterwards.
- R4: With phase 0, the first data bit is on the output line in the same cycle that select is asserted. The output changes only on trailing (second, fourth, ...) clock edges, and the input is sampled on leading (first, third, ...) edges.
- R5: With phase 1, the output line is low when select is asserted and the first bit appears on the first (leading) clock edge. The output changes on leading edges, and the input is sampled on trailing edges.
- R6: Bit order 0 sends and receives the most significant bit first. Bit order 1 sends and receives the least significant bit first. The same order applies in both directions.
- R7: The first clock edge comes divider+1 system clocks after select is asserted, and every later half-period is also divider+1 system clocks. The divider value in force is the one present at the start request.
- R8: Each transfer has exactly sixteen serial clock edges. Select is released divider+1 system clocks after the last of them.
- R9: Done is a one-cycle pulse in the cycle where select is released and busy falls. The received byte is valid from that cycle and holds until the next done pulse.
- R10: A start request while busy is ignored. The running transfer keeps its settings, and no second transfer follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start request, acted on only when idle |
| cfgCpol | input | 1 | Serial clock idle level |
| cfgCpha | input | 1 | 0: data valid at select; 1: data driven on first edge |
| cfgLsbFirst | input | 1 | 1: least significant bit first |
| cfgTarget | input | SEL_W | Index of the peripheral to address |
| cfgDiv | input | DIV_W | Half-period of the serial clock minus one, in system clocks |
| txByte | input | DATA_W | Byte to send |
| rxByte | output | DATA_W | Byte received in the last transfer |
| doneP | output | 1 | One-cycle end-of-transfer pulse |
| busy | output | 1 | High while a transfer runs |
| sck | output | 1 | Serial clock |
| csN | output | NUM_PERIPH | Active-low select, one per peripheral |
| pico | output | 1 | Serial data to the peripherals |
| poci | input | 1 | Serial data from the peripherals |

## Verification
The bench plays the peripheral. It follows the serial clock and select lines, shifts its own byte out on the edges that the mode allows, and captures what the controller sends. The main transfer is tried with all four polarity and phase combinations, each in both bit orders, with all four target indices and dividers from 0 to 4. The transmit and reply bytes are chosen to be asymmetric, so that a reversed bit order, a sample taken on the wrong edge or a missing first bit each produces a different wrong byte. Directed runs use the largest divider, which exposes counter wrap and capture faults. They also raise a start request with altered settings in the middle of a transfer, which separates settings captured at start from settings read live.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_TAIL  = 2'd2
  } seqState_t;

  // strobes from the sequencer to the datapath and select decoder
  typedef struct packed {
    logic load;      // transfer accepted this cycle
    logic shiftOut;  // present next bit on the output line
    logic sampleIn;  // capture the input line
    logic finish;    // release select, publish received byte
  } xferStb_t;

endpackage

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             cfgCpol,
  input  logic             cfgCpha,
  input  logic [DIV_W-1:0] cfgDiv,
  output xferStb_t         stb,
  output logic             sck,
  output logic             busy,
  output logic             doneP
);

  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES + 1);
  localparam logic [EDGE_W-1:0] LAST_IDX = EDGE_W'(EDGES - 1);

  seqState_t         state;
  logic [DIV_W-1:0]  hpCnt;
  logic [DIV_W-1:0]  divQ;
  logic [EDGE_W-1:0] edgeCnt;
  logic              sckQ;
  logic              cpolQ;
  logic              cphaQ;
  logic              doneQ;

  logic hpEnd;
  logic tick;
  logic leadNext;

  assign hpEnd    = (hpCnt == divQ);
  assign tick     = (state == SEQ_SHIFT) && hpEnd;
  assign leadNext = ~edgeCnt[0];  // next edge is odd-numbered, i.e. leading

  always_comb begin
    stb          = '0;
    stb.load     = (state == SEQ_IDLE) && startReq;
    stb.finish   = (state == SEQ_TAIL) && hpEnd;
    stb.sampleIn = tick && (cphaQ ? !leadNext : leadNext);
    stb.shiftOut = tick && (cphaQ ? leadNext
                                  : (!leadNext && (edgeCnt != LAST_IDX)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      hpCnt   <= '0;
      divQ    <= '0;
      edgeCnt <= '0;
      sckQ    <= 1'b0;
      cpolQ   <= 1'b0;
      cphaQ   <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (startReq) begin
            divQ    <= cfgDiv;
            cpolQ   <= cfgCpol;
            cphaQ   <= cfgCpha;
            sckQ    <= cfgCpol;
            hpCnt   <= '0;
            edgeCnt <= '0;
            state   <= SEQ_SHIFT;
          end
        end
        SEQ_SHIFT: begin
          if (hpEnd) begin
            hpCnt   <= '0;
            sckQ    <= ~sckQ;
            edgeCnt <= edgeCnt + 1'b1;
            if (edgeCnt == LAST_IDX) state <= SEQ_TAIL;
          end else begin
            hpCnt <= hpCnt + 1'b1;
          end
        end
        SEQ_TAIL: begin
          if (hpEnd) begin
            hpCnt <= '0;
            doneQ <= 1'b1;
            state <= SEQ_IDLE;
          end else begin
            hpCnt <= hpCnt + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign sck   = sckQ;
  assign busy  = (state != SEQ_IDLE);
  assign doneP = doneQ;

  // R7: the half-period counter never runs past the captured divider
  a_r7_hp_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state != SEQ_IDLE) |-> (hpCnt <= divQ));

  // R8: never more than sixteen edges in one transfer
  a_r8_edge_bound: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= EDGE_W'(EDGES));

  // R3: clock rests at the captured polarity whenever idle
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_IDLE) |-> (sckQ == cpolQ));

  // R9: done lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R10: a start while busy leaves the captured divider untouched
  a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rstN)
    ((state != SEQ_IDLE) && startReq) |=> $stable(divQ));

endmodule

// File: rtl/spi_xfer_shift.sv
module spi_xfer_shift
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStb_t          stb,
  input  logic              cfgCpha,
  input  logic              cfgLsbFirst,
  input  logic [DATA_W-1:0] txByte,
  input  logic              poci,
  output logic              pico,
  output logic [DATA_W-1:0] rxByte
);

  logic [DATA_W-1:0] txSh;
  logic [DATA_W-1:0] rxSh;
  logic [DATA_W-1:0] rxOut;
  logic              picoQ;
  logic              lsbQ;

  function automatic logic headBit(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[DATA_W-1];
  endfunction

  function automatic logic [DATA_W-1:0] advance(input logic [DATA_W-1:0] v,
                                                input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh  <= '0;
      rxSh  <= '0;
      rxOut <= '0;
      picoQ <= 1'b0;
      lsbQ  <= 1'b0;
    end else begin
      if (stb.load) begin
        lsbQ <= cfgLsbFirst;
        rxSh <= '0;
        if (!cfgCpha) begin
          picoQ <= headBit(txByte, cfgLsbFirst);
          txSh  <= advance(txByte, cfgLsbFirst);
        end else begin
          picoQ <= 1'b0;
          txSh  <= txByte;
        end
      end else begin
        if (stb.shiftOut) begin
          picoQ <= headBit(txSh, lsbQ);
          txSh  <= advance(txSh, lsbQ);
        end
        if (stb.sampleIn) begin
          rxSh <= lsbQ ? {poci, rxSh[DATA_W-1:1]} : {rxSh[DATA_W-2:0], poci};
        end
        if (stb.finish) begin
          rxOut <= rxSh;
          picoQ <= 1'b0;
        end
      end
    end
  end

  assign pico   = picoQ;
  assign rxByte = rxOut;

  // R4/R5: the output line never moves on a sampling strobe
  a_r4_stable_on_sample: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.sampleIn) |-> $stable(picoQ));

endmodule

// File: rtl/spi_xfer_csdec.sv
module spi_xfer_csdec
  import spi_xfer_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int SEL_W      = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  xferStb_t              stb,
  input  logic [SEL_W-1:0]      cfgTarget,
  output logic [NUM_PERIPH-1:0] csN
);

  logic [NUM_PERIPH-1:0] csReg;

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_sel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           csReg[i] <= 1'b1;
      else if (stb.load)   csReg[i] <= (cfgTarget != SEL_W'(i));
      else if (stb.finish) csReg[i] <= 1'b1;
    end
  end

  assign csN = csReg;

  // R2: at most one peripheral selected at any time
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csReg) <= 1);

endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 8,
  parameter int SEL_W      = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic                  cfgCpol,
  input  logic                  cfgCpha,
  input  logic                  cfgLsbFirst,
  input  logic [SEL_W-1:0]      cfgTarget,
  input  logic [DIV_W-1:0]      cfgDiv,
  input  logic [DATA_W-1:0]     txByte,
  output logic [DATA_W-1:0]     rxByte,
  output logic                  doneP,
  output logic                  busy,
  output logic                  sck,
  output logic [NUM_PERIPH-1:0] csN,
  output logic                  pico,
  input  logic                  poci
);

  xferStb_t stb;

  spi_xfer_seq #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uSeq (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .cfgCpol  (cfgCpol),
    .cfgCpha  (cfgCpha),
    .cfgDiv   (cfgDiv),
    .stb      (stb),
    .sck      (sck),
    .busy     (busy),
    .doneP    (doneP)
  );

  spi_xfer_shift #(.DATA_W(DATA_W)) uShift (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .cfgCpha     (cfgCpha),
    .cfgLsbFirst (cfgLsbFirst),
    .txByte      (txByte),
    .poci        (poci),
    .pico        (pico),
    .rxByte      (rxByte)
  );

  spi_xfer_csdec #(.NUM_PERIPH(NUM_PERIPH), .SEL_W(SEL_W)) uCs (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cfgTarget (cfgTarget),
    .csN       (csN)
  );

  // R2: no select line is low while the block is idle
  a_r2_idle_release: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (&csN));

  // R9: the received byte only moves together with done
  a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !doneP |-> $stable(rxByte));

endmodule

// File: tb/tb_spi_xfer_ctrl.sv
module tb_spi_xfer_ctrl;
  localparam int NP = 4;
  localparam int SW = 2;
  localparam int DW = 8;
  localparam int DIVW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, startReq = 1'b0;
  logic cfgCpol = 1'b0, cfgCpha = 1'b0, cfgLsbFirst = 1'b0;
  logic [SW-1:0]   cfgTarget = '0;
  logic [DIVW-1:0] cfgDiv = '0;
  logic [DW-1:0]   txByte = '0;
  logic [DW-1:0]   rxByte;
  logic doneP, busy, sck, pico;
  logic [NP-1:0] csN;
  logic poci = 1'b0;

  spi_xfer_ctrl #(.NUM_PERIPH(NP), .DATA_W(DW), .DIV_W(DIVW)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cfgCpol(cfgCpol),
    .cfgCpha(cfgCpha), .cfgLsbFirst(cfgLsbFirst), .cfgTarget(cfgTarget),
    .cfgDiv(cfgDiv), .txByte(txByte), .rxByte(rxByte), .doneP(doneP),
    .busy(busy), .sck(sck), .csN(csN), .pico(pico), .poci(poci)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // {cpol, cpha, lsbFirst, target[1:0], div[7:0], tx[7:0], reply[7:0]}
  localparam logic [28:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 8'd0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 1'b0, 2'd1, 8'd1, 8'h96, 8'hC3},
    {1'b1, 1'b0, 1'b0, 2'd2, 8'd2, 8'h5A, 8'h81},
    {1'b1, 1'b1, 1'b0, 2'd3, 8'd3, 8'hF0, 8'h0F},
    {1'b0, 1'b0, 1'b1, 2'd1, 8'd1, 8'h01, 8'h80},
    {1'b0, 1'b1, 1'b1, 2'd2, 8'd0, 8'hC8, 8'h37},
    {1'b1, 1'b0, 1'b1, 2'd3, 8'd4, 8'hE7, 8'h18},
    {1'b1, 1'b1, 1'b1, 2'd0, 8'd2, 8'h6B, 8'hD2}
  };

  // peripheral model settings (expected values)
  logic mCpha = 1'b0, mLsb = 1'b0;
  int   mDiv = 0;
  logic [SW-1:0] mTgt = '0;
  logic [DW-1:0] perTx = '0, perRx = '0;

  // observations
  int   edges = 0, sinceEvt = 0, pIdx = 0, sIdx = 0, relIv = 0;
  bit   prevSck = 1'b0, prevAct = 1'b0;
  bit   badIv = 1'b0, badCs = 1'b0, strayDone = 1'b0, idleBad = 1'b0;
  bit   relSeen = 1'b0, relDone = 1'b0, relBusy = 1'b0, relSck = 1'b0;
  bit   sckAtStart = 1'b0, firstPico = 1'b0;

  function automatic logic pbit(input int i);
    return mLsb ? perTx[i] : perTx[DW-1-i];
  endfunction

  always @(negedge clk) begin : mon
    bit act;
    bit lead;
    act = (csN != '1);
    sinceEvt++;
    if (act && !prevAct) begin
      edges = 0; sinceEvt = 0; badIv = 0; badCs = 0; perRx = '0;
      pIdx = 0; sIdx = 0;
      sckAtStart = sck; firstPico = pico;
      if (!mCpha) begin
        poci = pbit(0);
        pIdx = 1;
      end
    end else if (act && (sck != prevSck)) begin
      edges++;
      if (sinceEvt != mDiv + 1) badIv = 1;
      sinceEvt = 0;
      lead = edges[0];
      if (lead ^ mCpha) begin
        if (sIdx < DW) perRx[mLsb ? sIdx : DW-1-sIdx] = pico;
        sIdx++;
      end else begin
        if (pIdx < DW) poci = pbit(pIdx);
        pIdx++;
      end
    end else if (!act && prevAct) begin
      relIv = sinceEvt; relDone = doneP; relBusy = busy; relSck = sck;
      relSeen = 1;
    end else if (!act && !prevAct && (sck != prevSck) && !busy) begin
      idleBad = 1;
    end
    if (act && (csN != ~(NP'(1) << mTgt))) badCs = 1;
    if (doneP && !(!act && prevAct)) strayDone = 1;
    prevSck = sck;
    prevAct = act;
  end

  task automatic runXfer(input logic cpol, input logic cpha, input logic lsb,
                         input logic [SW-1:0] tgt, input logic [DIVW-1:0] div,
                         input logic [DW-1:0] tx, input logic [DW-1:0] prx,
                         input bit midStart);
    @(negedge clk);
    mCpha = cpha; mLsb = lsb; mDiv = int'(div); mTgt = tgt; perTx = prx;
    relSeen = 0; strayDone = 0;
    cfgCpol = cpol; cfgCpha = cpha; cfgLsbFirst = lsb;
    cfgTarget = tgt; cfgDiv = div; txByte = tx; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1'b1, "R2 busy after start", 32'(busy), 32'd1);
    if (midStart) begin
      repeat (5) @(negedge clk);
      cfgCpol = ~cpol; cfgCpha = ~cpha; cfgLsbFirst = ~lsb;
      cfgTarget = tgt + 1'b1; cfgDiv = '0; txByte = ~tx; startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
    end
    while (!relSeen) @(negedge clk);
    check(rxByte == prx, "R6 received byte", 32'(rxByte), 32'(prx));
    check(perRx == tx, "R6 byte seen by peripheral", 32'(perRx), 32'(tx));
    check(edges == 16, "R8 edge count", 32'(edges), 32'd16);
    check(!badIv, "R7 half-period length", 32'(badIv), 32'd0);
    check(relIv == mDiv + 1, "R8 select release delay", 32'(relIv), 32'(mDiv + 1));
    check(relDone && !relBusy, "R9 done with release", {30'd0, relDone, relBusy}, 32'h2);
    check(!badCs, "R2 only target selected", 32'(badCs), 32'd0);
    check(sckAtStart == cpol && relSck == cpol, "R3 idle clock level",
          {30'd0, sckAtStart, relSck}, {30'd0, cpol, cpol});
    if (cpha) check(firstPico == 1'b0, "R5 output low before first edge",
                    32'(firstPico), 32'd0);
    else      check(firstPico == tx[lsb ? 0 : DW-1], "R4 first bit at select",
                    32'(firstPico), 32'(tx[lsb ? 0 : DW-1]));
    check(!strayDone, "R9 no stray done", 32'(strayDone), 32'd0);
    repeat (4) @(negedge clk);
    check(!busy && (csN == '1) && (sck == cpol) && (rxByte == prx),
          midStart ? "R10 no transfer after ignored start" : "R9 idle hold",
          {22'd0, busy, csN, sck, 4'd0}, {22'd0, 1'b0, 4'hF, cpol, 4'd0});
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check((csN == '1) && !busy && !doneP && !sck && !pico, "R1 outputs in reset",
          {24'd0, csN, busy, doneP, sck, pico}, 32'hF0);
    rstN = 1'b1;
    @(negedge clk);
    check((csN == '1) && !busy && !doneP && !sck && !pico, "R1 outputs after reset",
          {24'd0, csN, busy, doneP, sck, pico}, 32'hF0);

    for (int v = 0; v < 8; v++) begin
      runXfer(VEC[v][28], VEC[v][27], VEC[v][26], VEC[v][25:24],
              VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 1'b0);
    end

    // R10: start with altered settings in the middle of a transfer
    runXfer(1'b0, 1'b1, 1'b0, 2'd2, 8'd3, 8'h3A, 8'hB4, 1'b1);
    // R7: largest divider
    runXfer(1'b1, 1'b0, 1'b0, 2'd1, 8'd255, 8'h9C, 8'h65, 1'b0);

    // R9: received byte holds through a long idle stretch
    begin
      bit moved;
      moved = 1'b0;
      for (int k = 0; k < 50; k++) begin
        @(negedge clk);
        if (rxByte != 8'h65) moved = 1'b1;
      end
      check(!moved, "R9 received byte holds", 32'(moved), 32'd0);
    end
    check(!idleBad, "R3 clock steady while idle", 32'(idleBad), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule